// File: doc/BRIEF.md
# In-Order Request/Acknowledge Checker

This block watches a one-bit request line and a one-bit acknowledge line and checks that every request is answered, once and in order, inside a bounded window. Each rising edge of the request line is a new request. It takes the next value of a ticket counter, and a timestamp from a free-running cycle counter is stored for it in a small FIFO. A serving counter points at the oldest pending request. An acknowledge retires only that request, so one acknowledge can never satisfy several pending requests.

Each retired request gives either a one-cycle pass pulse or a one-cycle fail pulse, together with its ticket number. The serving counter advances on both outcomes, so the next request is checked from the following cycle. Two sticky error flags report an acknowledge that arrives with nothing pending and a request edge that finds the FIFO full. The block sits beside a design under test as a synthesizable monitor.

Control is a two-state machine. `SV_IDLE` means no request is pending. `SV_HEAD` means the oldest request is under check. The transitions are:
- ARM: `SV_IDLE` to `SV_HEAD` on an accepted request edge.
- ADVANCE: stay in `SV_HEAD` when the head retires and another request remains or arrives.
- DRAIN: `SV_HEAD` to `SV_IDLE` when the last pending request retires and no new edge is accepted.
- HOLD: stay in the current state otherwise.

Top module: `ordered_ack_monitor`

## Requirements
- R1: Only a rising edge of `req_i` (high now, low in the previous cycle) is a request. Holding `req_i` high for several cycles issues one ticket.
- R2: Each accepted request takes the current ticket value, and the ticket counter then increments by one. `outstanding_o` rises by one in the cycle after the edge.
- R3: The age of a request is the number of clock edges since its request edge. An acknowledge seen while a request is the head, with an age from WIN_MIN (default 1) to WIN_MAX (default 10), retires it with `pass_o` high for the next cycle. `retired_ticket_o` then shows its ticket number.
- R4: A head request that reaches age WIN_MAX with no acknowledge retires with `fail_o` high for the next cycle. The next request becomes the head in the following cycle.
- R5: One acknowledge retires only the oldest pending request. Tickets retire in issue order 0, 1, 2, … and the serving counter advances on both pass and fail.
- R6: An acknowledge while nothing is pending sets `orphan_err_o`, which stays high until reset.
- R7: An acknowledge in the same cycle as a request edge never retires that new request. It goes to an older pending request, or it is an orphan if none is pending.
- R8: The FIFO holds FIFO_DEPTH (default 8) timestamps. A request edge that finds it full, in a cycle where the head is not retiring, sets sticky `overflow_err_o`. That edge takes no ticket and leaves `outstanding_o` unchanged. A full FIFO whose head retires in the same cycle accepts the edge.
- R9: `pass_o` and `fail_o` are never high together, and at most one request retires per cycle.
- R10: A synchronous active-high `rst` clears both counters, the FIFO, the pulses, `retired_ticket_o` and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request line, edge-detected |
| ack_i | input | 1 | Acknowledge line |
| pass_o | output | 1 | One-cycle pulse: head request acknowledged in window |
| fail_o | output | 1 | One-cycle pulse: head request timed out |
| retired_ticket_o | output | TKT_W | Ticket of the most recently retired request |
| outstanding_o | output | $clog2(FIFO_DEPTH+1) | Number of pending requests |
| orphan_err_o | output | 1 | Sticky: acknowledge with nothing pending |
| overflow_err_o | output | 1 | Sticky: request edge dropped on a full FIFO |

## Verification
The window assertions assume that two request edges are at least two cycles apart. This holds for any single-bit line, because a rising edge needs a low cycle between rises. As a result, the next head is always younger than WIN_MAX when it takes over. The bench sweeps the acknowledge delay of a single request over every age from 1 to 12. It then drives short scenarios built as bit masks, one bit per clock edge: chained timeouts, overlapping requests, same-cycle edges and acknowledges, and a FIFO shrunk to four entries so that overflow is reachable inside the window. Expected pulses, ticket numbers and counts are derived arithmetically from those masks.

// File: rtl/oam_pkg.sv
package oam_pkg;

    typedef enum logic [0:0] {
        SV_IDLE = 1'b0,
        SV_HEAD = 1'b1
    } serve_state_t;

endpackage

// File: rtl/oam_issue.sv
module oam_issue #(
    parameter int TKT_W = 8,
    parameter int TS_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             accept_i,
    output logic             edge_o,
    output logic [TKT_W-1:0] ticket_o,
    output logic [TS_W-1:0]  now_o
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            ticket_o <= '0;
            now_o    <= '0;
        end else begin
            req_q <= req_i;
            now_o <= now_o + 1'b1;
            if (accept_i) begin
                ticket_o <= ticket_o + 1'b1;
            end
        end
    end

    assign edge_o = req_i & ~req_q;

    // R1
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_i && !req_q) |=> ticket_o == $past(ticket_o));

endmodule

// File: rtl/oam_stamp_fifo.sv
module oam_stamp_fifo #(
    parameter int DEPTH = 8,
    parameter int TS_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [TS_W-1:0]            din_i,
    output logic [TS_W-1:0]            head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TS_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (push_i) begin
                wr_ptr <= step(wr_ptr);
            end
            if (pop_i) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({push_i, pop_i})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (push_i && wr_ptr == PTR_W'(g)) begin
                mem[g] <= din_i;
            end
        end
    end

    assign head_o = mem[rd_ptr];
    assign full_o = (count_o == CNT_W'(DEPTH));

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_o <= CNT_W'(DEPTH));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(push_i && count_o == CNT_W'(DEPTH) && !pop_i));

endmodule

// File: rtl/oam_serve_fsm.sv
module oam_serve_fsm
    import oam_pkg::*;
#(
    parameter int TKT_W   = 8,
    parameter int TS_W    = 5,
    parameter int CNT_W   = 4,
    parameter int WIN_MIN = 1,
    parameter int WIN_MAX = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_i,
    input  logic             edge_i,
    input  logic             full_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [TS_W-1:0]  head_ts_i,
    input  logic [TS_W-1:0]  now_i,
    output logic             accept_o,
    output logic             retire_o,
    output logic             pass_o,
    output logic             fail_o,
    output logic [TKT_W-1:0] retired_o,
    output logic [TKT_W-1:0] serving_o,
    output logic             orphan_o,
    output logic             overflow_o
);

    serve_state_t st;
    serve_state_t nxt;
    logic [TS_W-1:0] age;
    logic            in_time;

    assign age      = now_i - head_ts_i;
    assign in_time  = ack_i && (age >= TS_W'(WIN_MIN));
    assign retire_o = (st == SV_HEAD) && (ack_i || age == TS_W'(WIN_MAX));
    assign accept_o = edge_i && (!full_i || retire_o);

    // ARM / ADVANCE / DRAIN / HOLD
    always_comb begin
        nxt = st;
        unique case (st)
            SV_IDLE: if (accept_o) nxt = SV_HEAD;
            SV_HEAD: if (retire_o && count_i == CNT_W'(1) && !accept_o) nxt = SV_IDLE;
            default: nxt = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SV_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_o     <= 1'b0;
            fail_o     <= 1'b0;
            retired_o  <= '0;
            serving_o  <= '0;
            orphan_o   <= 1'b0;
            overflow_o <= 1'b0;
        end else begin
            pass_o <= retire_o && in_time;
            fail_o <= retire_o && !in_time;
            if (retire_o) begin
                retired_o <= serving_o;
                serving_o <= serving_o + 1'b1;
            end
            if (st == SV_IDLE && ack_i) begin
                orphan_o <= 1'b1;
            end
            if (edge_i && !accept_o) begin
                overflow_o <= 1'b1;
            end
        end
    end

    // R3
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SV_HEAD) |-> (age >= TS_W'(1) && age <= TS_W'(WIN_MAX)));

    // R3
    ack_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SV_HEAD && ack_i && age >= TS_W'(WIN_MIN)) |=> (pass_o && !fail_o));

    // R4
    timeout_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SV_HEAD && !ack_i && age == TS_W'(WIN_MAX)) |=> fail_o);

    // R5
    serve_step_chk: assert property (@(posedge clk) disable iff (rst)
        retire_o |=> serving_o == $past(serving_o) + 1'b1);

    // R6
    orphan_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SV_IDLE && ack_i) |=> orphan_o);

    // R8
    idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SV_IDLE) == (count_i == '0));

    // R9
    single_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o));

endmodule

// File: rtl/ordered_ack_monitor.sv
module ordered_ack_monitor #(
    parameter int FIFO_DEPTH = 8,
    parameter int WIN_MIN    = 1,
    parameter int WIN_MAX    = 10,
    parameter int TKT_W      = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_i,
    input  logic                            ack_i,
    output logic                            pass_o,
    output logic                            fail_o,
    output logic [TKT_W-1:0]                retired_ticket_o,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] outstanding_o,
    output logic                            orphan_err_o,
    output logic                            overflow_err_o
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int TS_W  = $clog2(WIN_MAX + 1) + 1;

    logic             req_edge;
    logic             accept;
    logic             retire;
    logic             full;
    logic [TKT_W-1:0] ticket;
    logic [TKT_W-1:0] serving;
    logic [TS_W-1:0]  now;
    logic [TS_W-1:0]  head_ts;

    oam_issue #(.TKT_W(TKT_W), .TS_W(TS_W)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .accept_i (accept),
        .edge_o   (req_edge),
        .ticket_o (ticket),
        .now_o    (now)
    );

    oam_stamp_fifo #(.DEPTH(FIFO_DEPTH), .TS_W(TS_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (accept),
        .pop_i   (retire),
        .din_i   (now),
        .head_o  (head_ts),
        .count_o (outstanding_o),
        .full_o  (full)
    );

    oam_serve_fsm #(
        .TKT_W(TKT_W), .TS_W(TS_W), .CNT_W(CNT_W),
        .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)
    ) u_serve (
        .clk        (clk),
        .rst        (rst),
        .ack_i      (ack_i),
        .edge_i     (req_edge),
        .full_i     (full),
        .count_i    (outstanding_o),
        .head_ts_i  (head_ts),
        .now_i      (now),
        .accept_o   (accept),
        .retire_o   (retire),
        .pass_o     (pass_o),
        .fail_o     (fail_o),
        .retired_o  (retired_ticket_o),
        .serving_o  (serving),
        .orphan_o   (orphan_err_o),
        .overflow_o (overflow_err_o)
    );

    // R2
    ticket_balance_chk: assert property (@(posedge clk) disable iff (rst)
        TKT_W'(outstanding_o) == TKT_W'(ticket - serving));

endmodule

// File: tb/ordered_ack_monitor_test.sv
module ordered_ack_monitor_test;

    localparam int DEPTH = 4;
    localparam int TKT_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             req;
    logic             ack;
    logic             pass_o;
    logic             fail_o;
    logic [TKT_W-1:0] retired;
    logic [2:0]       outstanding;
    logic             orphan;
    logic             overflow;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ordered_ack_monitor #(.FIFO_DEPTH(DEPTH), .WIN_MIN(1), .WIN_MAX(10), .TKT_W(TKT_W)) uut (
        .clk              (clk),
        .rst              (rst),
        .req_i            (req),
        .ack_i            (ack),
        .pass_o           (pass_o),
        .fail_o           (fail_o),
        .retired_ticket_o (retired),
        .outstanding_o    (outstanding),
        .orphan_err_o     (orphan),
        .overflow_err_o   (overflow)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [31:0] bit_at(input int n);
        return (n >= 0 && n < 32) ? (32'd1 << n) : 32'd0;
    endfunction

    // One bit per clock edge e: rq/ak are the inputs sampled at edge e,
    // iss marks accepted request edges, ps/fl the expected verdict of edge e.
    task automatic run_scn(input string tag, input logic [31:0] rq, input logic [31:0] ak,
                           input logic [31:0] iss, input logic [31:0] ps, input logic [31:0] fl,
                           input int orph, input int ovf);
        int issued  = 0;
        int retires = 0;
        rst = 1'b1; req = 1'b0; ack = 1'b0;
        tick(); tick();
        rst = 1'b0;
        // R10 reset state
        chk({tag, " R10 pass"}, int'(pass_o), 0);
        chk({tag, " R10 fail"}, int'(fail_o), 0);
        chk({tag, " R10 ticket"}, int'(retired), 0);
        chk({tag, " R10 outstanding"}, int'(outstanding), 0);
        chk({tag, " R10 orphan"}, int'(orphan), 0);
        chk({tag, " R10 overflow"}, int'(overflow), 0);
        for (int e = 0; e < 32; e++) begin
            req = rq[e];
            ack = ak[e];
            tick();
            if (iss[e]) issued++;
            chk($sformatf("%s e=%0d pass", tag, e), int'(pass_o), int'(ps[e]));
            chk($sformatf("%s e=%0d fail", tag, e), int'(fail_o), int'(fl[e]));
            chk($sformatf("%s e=%0d R9 one verdict", tag, e), int'(pass_o && fail_o), 0);
            if (ps[e] || fl[e]) begin
                chk($sformatf("%s e=%0d R5 ticket", tag, e), int'(retired), retires);
                retires++;
            end
            chk($sformatf("%s e=%0d R2 outstanding", tag, e), int'(outstanding), issued - retires);
            chk($sformatf("%s e=%0d R6 orphan", tag, e), int'(orphan), int'(orph >= 0 && e >= orph));
            chk($sformatf("%s e=%0d R8 overflow", tag, e), int'(overflow), int'(ovf >= 0 && e >= ovf));
        end
        req = 1'b0;
        ack = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req = 1'b0; ack = 1'b0;

        // R3 R4: one request, acknowledge after every delay 1..12
        for (int a = 1; a <= 12; a++) begin
            if (a <= 10)
                run_scn($sformatf("R3 sweep a=%0d", a), bit_at(0), bit_at(a), bit_at(0),
                        bit_at(a), 32'd0, -1, -1);
            else
                run_scn($sformatf("R4 sweep a=%0d", a), bit_at(0), bit_at(a), bit_at(0),
                        32'd0, bit_at(10), a, -1);
        end

        // R1: request held high six cycles counts once
        run_scn("R1 level", 32'h3F, bit_at(8), bit_at(0), bit_at(8), 32'd0, -1, -1);

        // R5: three pending, acks retire them one at a time in order
        run_scn("R5 in order", bit_at(0) | bit_at(2) | bit_at(4), bit_at(5) | bit_at(7) | bit_at(9),
                bit_at(0) | bit_at(2) | bit_at(4), bit_at(5) | bit_at(7) | bit_at(9), 32'd0, -1, -1);

        // R4: chained timeouts, next head checked after the first fails
        run_scn("R4 chained", bit_at(0) | bit_at(2), 32'd0, bit_at(0) | bit_at(2),
                32'd0, bit_at(10) | bit_at(12), -1, -1);

        // R7: ack with a new edge retires the older request only
        run_scn("R7 same cycle", bit_at(0) | bit_at(3), bit_at(3), bit_at(0) | bit_at(3),
                bit_at(3), bit_at(13), -1, -1);

        // R7 R6: ack with an edge into an empty checker is an orphan
        run_scn("R7 empty same cycle", bit_at(0), bit_at(0), bit_at(0),
                32'd0, bit_at(10), 0, -1);

        // R6: second ack after the only request retired
        run_scn("R6 orphan", bit_at(0), bit_at(2) | bit_at(4), bit_at(0),
                bit_at(2), 32'd0, 4, -1);

        // R8: fifth edge on a full FIFO dropped, takes no ticket
        run_scn("R8 overflow", bit_at(0) | bit_at(2) | bit_at(4) | bit_at(6) | bit_at(8) | bit_at(18),
                bit_at(20), bit_at(0) | bit_at(2) | bit_at(4) | bit_at(6) | bit_at(18),
                bit_at(20), bit_at(10) | bit_at(12) | bit_at(14) | bit_at(16), -1, 8);

        // R8: full FIFO whose head retires in the same cycle accepts the edge
        run_scn("R8 full with retire", bit_at(0) | bit_at(2) | bit_at(4) | bit_at(6) | bit_at(8),
                bit_at(8), bit_at(0) | bit_at(2) | bit_at(4) | bit_at(6) | bit_at(8),
                bit_at(8), bit_at(12) | bit_at(14) | bit_at(16) | bit_at(18), -1, -1);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule